// File: doc/BRIEF.md
# Pulse/Level Interrupt Request Generator

This block merges the interrupt requests of several card functions onto one active-low request line toward the host. Each function supplies an interrupt input and an enable. The inputs pass through a two-stage synchronizer. The enabled, asserted inputs are ORed into one internal level, and that level drives the request line in one of two ways.

The choice is made by a single shared mode bit. In pulse mode, each rising edge of the internal level produces one low pulse of fixed length. In level mode, the line stays low for as long as the level is asserted.

A re-evaluate strobe, raised by the register logic after the host has finished its end-of-interrupt handling, asks the block for a fresh edge if an enabled interrupt is still pending. In pulse mode this gives a new pulse. In level mode it gives a short high release followed by a return to low. Pulses never overlap: any event that arrives while a pulse is running is held and issued after that pulse.

Top module: `irq_req_gen`

## Requirements
- R1: The internal level is the OR of every input that is both asserted and enabled. An asserted input whose enable is 0 leaves `irq_n` high.
- R2: While `rst_n` is low, and on the first cycle after it is released, `irq_n` is high.
- R3: In level mode, `irq_n` goes low 3 clock edges after an enabled input rises. It stays low while the level holds and returns high 3 edges after the last enabled input falls.
- R4: In pulse mode, a rising edge of the internal level drives `irq_n` low for exactly PULSE_CYCLES cycles. A level that stays asserted after that produces no further pulse.
- R5: In pulse mode, a `reeval` strobe seen while the level is asserted produces one more PULSE_CYCLES-long low pulse.
- R6: A `reeval` strobe seen while the level is low leaves `irq_n` high, in both modes.
- R7: In level mode, a `reeval` strobe seen while the level is asserted drives `irq_n` high for RELEASE_CYCLES cycles, after which `irq_n` returns low and stays low while the level holds.
- R8: In pulse mode, an event that arrives during a pulse is queued. It is issued as a separate pulse after at least one high cycle.
- R9: `level_mode` = 1 selects level mode and `level_mode` = 0 selects pulse mode. In level mode a held interrupt keeps `irq_n` low for longer than PULSE_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| func_int | input | NUM_FUNC | Interrupt input of each function, active high, asynchronous |
| func_en | input | NUM_FUNC | Interrupt enable of each function |
| level_mode | input | 1 | 1 selects level mode, 0 selects pulse mode |
| reeval | input | 1 | One-cycle re-evaluate strobe |
| irq_n | output | 1 | Active-low interrupt request toward the host |

## Verification
In pulse mode, the stimulus includes:
- a single rising input that is held, which separates edge-triggered behaviour from level following;
- a strobe issued while the level is held, and a second one issued while a pulse is still running, which shows whether events are queued or lost.

In level mode, the stimulus includes:
- one input held for a known number of cycles, which fixes the latency;
- two overlapping inputs, which should merge into one low run and so show the OR;
- a strobe issued mid-run, whose run lengths split at the release.

Further cases cover a disabled input that toggles and strobes issued with no level present. These show that such inputs have no effect.

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int NUM_FUNC       = 2,
  parameter int PULSE_CYCLES   = 25,
  parameter int RELEASE_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_FUNC-1:0] func_int,
  input  logic [NUM_FUNC-1:0] func_en,
  input  logic                level_mode,
  input  logic                reeval,
  output logic                irq_n
);

  localparam int MAX_CYC = (PULSE_CYCLES > RELEASE_CYCLES) ? PULSE_CYCLES : RELEASE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_PULSE, S_REL} state_t;

  logic [NUM_FUNC-1:0] sync1, sync2;
  logic                lvl_any, lvl_q, rise, evt, pend;
  logic [CNT_W-1:0]    cnt;
  state_t              state;

  assign lvl_any = |(sync2 & func_en);
  assign rise    = lvl_any & ~lvl_q;
  assign evt     = rise | (reeval & lvl_any);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      lvl_q <= 1'b0;
    end else begin
      sync1 <= func_int;
      sync2 <= sync1;
      lvl_q <= lvl_any;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      pend  <= 1'b0;
      irq_n <= 1'b1;
    end else if (level_mode) begin
      pend <= 1'b0;
      if (state == S_REL) begin
        if (cnt == '0) begin
          state <= S_IDLE;
          irq_n <= ~lvl_any;
        end else begin
          cnt   <= cnt - 1'b1;
          irq_n <= 1'b1;
        end
      end else if (reeval && lvl_any) begin
        state <= S_REL;
        cnt   <= CNT_W'(RELEASE_CYCLES - 1);
        irq_n <= 1'b1;
      end else begin
        state <= S_IDLE;
        irq_n <= ~lvl_any;
      end
    end else begin
      case (state)
        S_PULSE: begin
          if (evt) pend <= 1'b1;
          if (cnt == '0) begin
            state <= S_IDLE;
            irq_n <= 1'b1;
          end else begin
            cnt   <= cnt - 1'b1;
            irq_n <= 1'b0;
          end
        end
        S_IDLE: begin
          if (evt || pend) begin
            state <= S_PULSE;
            cnt   <= CNT_W'(PULSE_CYCLES - 1);
            pend  <= 1'b0;
            irq_n <= 1'b0;
          end else begin
            irq_n <= 1'b1;
          end
        end
        default: begin
          state <= S_IDLE;
          irq_n <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/irq_req_gen_chk.sv
module irq_req_gen_chk #(
  parameter int PULSE_CYCLES = 25
) (
  input logic clk,
  input logic rst_n,
  input logic level_mode,
  input logic reeval,
  input logic lvl,
  input logic irq_n
);

  localparam int RW = $clog2(PULSE_CYCLES + 2) + 1;

  logic [RW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           low_run <= '0;
    else if (irq_n)                       low_run <= '0;
    else if (low_run != {RW{1'b1}})       low_run <= low_run + 1'b1;
  end

  assert_reset_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> irq_n);

  assert_level_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && !lvl) |=> irq_n);

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && $stable(level_mode) && $rose(irq_n)) |-> (low_run == RW'(PULSE_CYCLES)));

  assert_reeval_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && reeval && lvl && !irq_n) |=> irq_n);

endmodule

bind irq_req_gen irq_req_gen_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .level_mode(level_mode),
  .reeval(reeval), .lvl(lvl_any), .irq_n(irq_n)
);

// File: tb/sim_irq_req_gen.sv
module sim_irq_req_gen;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE      = 6;
  localparam int REL        = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] func_int = '0;
  logic [1:0] func_en = '0;
  logic       level_mode = 1'b0;
  logic       reeval = 1'b0;
  logic       irq_n;

  int checks = 0;
  int fails = 0;
  int exp_len[$];
  string exp_tag[$];
  int run = 0;

  irq_req_gen #(.NUM_FUNC(2), .PULSE_CYCLES(PULSE), .RELEASE_CYCLES(REL)) u0 (
    .clk(clk), .rst_n(rst_n), .func_int(func_int), .func_en(func_en),
    .level_mode(level_mode), .reeval(reeval), .irq_n(irq_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_run(input int len, input string tag);
    exp_len.push_back(len);
    exp_tag.push_back(tag);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe();
    reeval = 1'b1;
    cyc(1);
    reeval = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!irq_n) run++;
      else if (run > 0) begin
        if (exp_len.size() == 0) begin
          check(1'b0, "R6 unexpected low run", run, 0);
        end else begin
          int e;
          string t;
          e = exp_len.pop_front();
          t = exp_tag.pop_front();
          check(run == e, t, run, e);
        end
        run = 0;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    cyc(3);
    check(irq_n == 1'b1, "R2 reset level", int'(irq_n), 1);
    rst_n = 1'b1;
    cyc(1);
    check(irq_n == 1'b1, "R2 after release", int'(irq_n), 1);

    func_en = 2'b11;
    expect_run(PULSE, "R4 pulse width");
    func_int[0] = 1'b1;
    cyc(20);
    check(exp_len.size() == 0, "R4 single pulse for held input", exp_len.size(), 0);
    expect_run(PULSE, "R5 reeval pulse");
    strobe();
    cyc(15);
    check(exp_len.size() == 0, "R5 reeval pulse seen", exp_len.size(), 0);
    func_int = '0;
    cyc(10);

    func_en = 2'b01;
    func_int[1] = 1'b1;
    cyc(15);
    check(irq_n == 1'b1, "R1 disabled input ignored", int'(irq_n), 1);
    func_int = '0;
    cyc(5);
    func_en = 2'b11;

    strobe();
    cyc(10);
    check(irq_n == 1'b1, "R6 pulse mode idle reeval", int'(irq_n), 1);

    expect_run(PULSE, "R8 first pulse");
    expect_run(PULSE, "R8 queued pulse");
    func_int[0] = 1'b1;
    cyc(5);
    strobe();
    cyc(25);
    check(exp_len.size() == 0, "R8 both pulses issued", exp_len.size(), 0);
    func_int = '0;
    cyc(10);

    level_mode = 1'b1;
    cyc(2);
    expect_run(5, "R3 level follows input");
    func_int[1] = 1'b1;
    cyc(5);
    func_int[1] = 1'b0;
    cyc(10);

    expect_run(8, "R1 OR of overlapping inputs");
    func_int[0] = 1'b1;
    cyc(2);
    func_int[1] = 1'b1;
    cyc(2);
    func_int[0] = 1'b0;
    cyc(4);
    func_int[1] = 1'b0;
    cyc(10);

    expect_run(11, "R7 run before release");
    expect_run(6, "R7 run after release");
    func_int[0] = 1'b1;
    cyc(13);
    check(irq_n == 1'b0, "R9 level mode holds past pulse width", int'(irq_n), 0);
    strobe();
    cyc(5);
    func_int[0] = 1'b0;
    cyc(10);
    check(exp_len.size() == 0, "R7 release split seen", exp_len.size(), 0);

    strobe();
    cyc(10);
    check(irq_n == 1'b1, "R6 level mode idle reeval", int'(irq_n), 1);
    check(exp_len.size() == 0, "R6 no outstanding runs", exp_len.size(), 0);

    summary();
  end
endmodule